// File: doc/BRIEF.md
# Packed-Pixel Scan-Line Unpacker

The unpacker takes one scan line of pixels packed into 32-bit memory words and hands them out one pixel per output beat. Two packings are handled: 16 bits per pixel, two pixels to a word, and 24 bits per pixel, four pixels to three words. In the 24-bit packing a pixel may straddle two words. The unpacker keeps the upper leftover bits of one word and joins the lower bits of the next word above them, so the lower-addressed bits land in the low part of the pixel.

A start pulse loads a line descriptor. The descriptor gives the packing, the bit where the first pixel begins in the first word, the bit where the last pixel begins in the final word, and the number of words in the line minus one. Words arrive on a valid/ready input and pixels leave on a valid/ready output. The final pixel carries a last flag. Bit positions are counted across the line from bit 0 of the first word. Every pixel whose starting position lies from the start bit up to `word_count*32 + end_bit` is emitted.

Top module: `pixel_unpacker`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle on the next edge: `busy`, `px_valid` and `in_ready` are 0, and no partial pixel from an aborted line shows up in the next line.
- R2: When idle, a `start` pulse loads the descriptor, and `busy` is 1 from the following clock edge.
- R3: With `mode24` = 0 (16 bpp), bits 15:0 of a word form the earlier pixel and bits 31:16 the later one. `px_data[23:16]` is 0.
- R4: With `mode24` = 1 (24 bpp), pixel k of a three-word group starts at bit 24k of the group. Pixels crossing a word boundary take the upper bits of the earlier word as their low bits and the lower bits of the next word as their high bits.
- R5: The bits of the first word below `start_bit` are skipped, and the first pixel begins at `start_bit`.
- R6: Each pixel starts `bpp` bits after the previous one. `px_last` is 1 on exactly one pixel: the last one whose start position is not above `word_cnt*32 + end_bit`. No pixel follows it.
- R7: Exactly `word_cnt + 1` words are accepted per line. Words still due after the last pixel are accepted and discarded, then `busy` returns to 0.
- R8: While a complete pixel waits on `px_ready`, `in_ready` is 0, and `px_data`/`px_last` stay stable. No pixel is lost or repeated under any valid/ready pattern.
- R9: A `start` pulse while `busy` is 1 is ignored, and the line in progress continues with its original descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load descriptor and begin a line (idle only) |
| mode24 | input | 1 | 1 selects 24 bpp, 0 selects 16 bpp |
| start_bit | input | 5 | Bit where the first pixel begins in the first word |
| end_bit | input | 5 | Bit where the last pixel begins in the final word |
| word_cnt | input | WCW | Words in the line minus one |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| px_valid | output | 1 | Output pixel valid |
| px_data | output | 24 | Pixel, zero-extended in 16 bpp |
| px_last | output | 1 | Final pixel of the line |
| px_ready | input | 1 | Downstream accepts the pixel |
| busy | output | 1 | A line is in progress |

## Verification
`busy` is due one edge after the start pulse. A pixel completed by an accepted word is valid one edge after that word's acceptance, and the next buffered pixel follows one edge after each output handshake. `busy` falls one edge after the final word has gone and the last pixel has left. The bench drives inputs and samples outputs on the falling edge. At each falling edge it compares the presented pixel with the head of a queue computed from the line's bit vector, and it decides the handshakes that the next rising edge will perform. Every cycle it also checks that no word is offered for acceptance while a pixel is pending.

// File: rtl/pixel_unpacker.sv
module pixel_unpacker #(
  parameter int WCW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           mode24,
  input  logic [4:0]     start_bit,
  input  logic [4:0]     end_bit,
  input  logic [WCW-1:0] word_cnt,
  input  logic           in_valid,
  input  logic [31:0]    in_data,
  output logic           in_ready,
  output logic           px_valid,
  output logic [23:0]    px_data,
  output logic           px_last,
  input  logic           px_ready,
  output logic           busy
);
  localparam int PW = WCW + 6;

  logic [55:0]   acc;
  logic [5:0]    fill;
  logic [WCW:0]  wl;
  logic [PW-1:0] nxt, lastp;
  logic [4:0]    sbit;
  logic          m24, first, done_px;

  wire [5:0]  bpp      = m24 ? 6'd24 : 6'd16;
  wire        has_px   = fill >= bpp;
  wire [55:0] word_in  = first ? {24'd0, in_data >> sbit} : ({24'd0, in_data} << fill);
  wire [5:0]  word_len = first ? 6'd32 - {1'b0, sbit} : 6'd32;
  wire        finish   = busy && wl == '0 && (done_px || !has_px);

  assign px_valid = busy && !done_px && has_px;
  assign px_data  = m24 ? acc[23:0] : {8'd0, acc[15:0]};
  assign px_last  = px_valid && (nxt + PW'(bpp) > lastp);
  assign in_ready = busy && wl != '0 && (done_px || !has_px);

  wire px_fire = px_valid && px_ready;
  wire in_fire = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      acc     <= '0;
      fill    <= '0;
      wl      <= '0;
      nxt     <= '0;
      lastp   <= '0;
      sbit    <= '0;
      m24     <= 1'b0;
      first   <= 1'b0;
      done_px <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        m24     <= mode24;
        sbit    <= start_bit;
        nxt     <= PW'(start_bit);
        lastp   <= {1'b0, word_cnt, end_bit};
        wl      <= {1'b0, word_cnt} + {{WCW{1'b0}}, 1'b1};
        first   <= 1'b1;
        done_px <= 1'b0;
        acc     <= '0;
        fill    <= '0;
      end
    end else begin
      if (in_fire) begin
        wl    <= wl - {{WCW{1'b0}}, 1'b1};
        first <= 1'b0;
        if (!done_px) begin
          acc  <= acc | word_in;
          fill <= fill + word_len;
        end
      end
      if (px_fire) begin
        acc  <= acc >> bpp;
        fill <= fill - bpp;
        nxt  <= nxt + PW'(bpp);
        if (px_last) done_px <= 1'b1;
      end
      if (finish) begin
        busy <= 1'b0;
        acc  <= '0;
        fill <= '0;
      end
    end
  end
endmodule

module pixel_unpacker_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        in_ready,
  input logic        px_valid,
  input logic [23:0] px_data,
  input logic        px_last,
  input logic        px_ready,
  input logic        busy
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!busy && !px_valid && !in_ready));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  p_single_last_r6: assert property (@(posedge clk) disable iff (rst)
    (px_valid && px_ready && px_last) |=> !px_valid);

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    !(px_valid && in_ready));

  p_hold_pixel_r8: assert property (@(posedge clk) disable iff (rst)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_data) && $stable(px_last)));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!px_valid && !in_ready));
endmodule

bind pixel_unpacker pixel_unpacker_chk chk (
  .clk(clk), .rst(rst), .start(start), .in_ready(in_ready),
  .px_valid(px_valid), .px_data(px_data), .px_last(px_last),
  .px_ready(px_ready), .busy(busy)
);

// File: tb/pixel_unpacker_test.sv
module pixel_unpacker_test;
  logic clk = 0, rst = 1, start = 0, mode24 = 0;
  logic [4:0] start_bit = 0, end_bit = 0;
  logic [7:0] word_cnt = 0;
  logic in_valid = 0, px_ready = 0;
  logic [31:0] in_data = 0;
  logic in_ready, px_valid, px_last, busy;
  logic [23:0] px_data;

  int checks = 0, errors = 0, cycles = 0;

  pixel_unpacker #(.WCW(8)) uut (
    .clk(clk), .rst(rst), .start(start), .mode24(mode24),
    .start_bit(start_bit), .end_bit(end_bit), .word_cnt(word_cnt),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .px_valid(px_valid), .px_data(px_data), .px_last(px_last),
    .px_ready(px_ready), .busy(busy)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [31:0] wd [16];
  logic [511:0] linev;
  logic [23:0] q_data [$];
  bit          q_last [$];

  task automatic run_line(input bit m, input int s, input int w, input int e,
                          input int rdy, input int vld, input bit poke, input string tag);
    int bpp, lastp, widx, seen_last, n, extra;
    bpp = m ? 24 : 16;
    lastp = w * 32 + e;
    linev = '0;
    for (int i = 0; i <= w; i++) begin
      wd[i] = $urandom;
      linev[i*32 +: 32] = wd[i];
    end
    q_data.delete();
    q_last.delete();
    for (int p = s; p <= lastp; p += bpp) begin
      q_data.push_back(m ? linev[p +: 24] : {8'd0, linev[p +: 16]});
      q_last.push_back(p + bpp > lastp);
    end
    @(negedge clk);
    start = 1; mode24 = m; start_bit = 5'(s); end_bit = 5'(e); word_cnt = 8'(w);
    @(negedge clk);
    start = 0;
    check(busy == 1, "R2", "busy after start", 32'(busy), 1);
    widx = 0; seen_last = 0; n = 0; extra = 0;
    while (busy && n < 2000) begin
      n++;
      if (px_valid && in_ready) check(0, "R8", "in_ready while pixel pending", 1, 0);
      if (px_valid) begin
        if (q_data.size() == 0) begin
          if (extra == 0) check(0, "R6", "pixel after last", 32'(px_data), 0);
          extra++;
        end else begin
          check(px_data == q_data[0], tag, "pixel data", 32'(px_data), 32'(q_data[0]));
          check(px_last == q_last[0], "R6", "last flag", 32'(px_last), 32'(q_last[0]));
        end
      end
      start = poke && (n == 3);
      if (start) begin
        mode24 = !m; start_bit = 5'd0; end_bit = 5'd0; word_cnt = 8'd0;
      end
      px_ready = ($urandom % 100) < rdy;
      if (px_valid && px_ready && q_data.size() > 0) begin
        if (q_last[0]) seen_last++;
        void'(q_data.pop_front());
        void'(q_last.pop_front());
      end
      in_valid = (widx <= w) && (($urandom % 100) < vld);
      in_data = in_valid ? wd[widx] : 32'hdead_beef;
      if (in_valid && in_ready) widx++;
      @(negedge clk);
    end
    start = 0; in_valid = 0; px_ready = 0;
    check(!busy, "R7", "line ends", 32'(busy), 0);
    check(widx == w + 1, "R7", "words accepted", 32'(widx), 32'(w + 1));
    check(q_data.size() == 0, poke ? "R9" : "R6", "pixels left", 32'(q_data.size()), 0);
    check(seen_last == 1, "R6", "last count", 32'(seen_last), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!busy && !px_valid && !in_ready, "R1", "reset state",
          {29'd0, busy, px_valid, in_ready}, 0);

    run_line(0, 16, 4, 0, 100, 100, 0, "R3");
    run_line(1, 0, 2, 8, 100, 100, 0, "R4");
    run_line(1, 24, 5, 0, 100, 100, 0, "R5");
    run_line(0, 0, 0, 16, 100, 100, 0, "R3");
    run_line(1, 0, 0, 0, 100, 100, 0, "R4");
    run_line(1, 8, 11, 8, 40, 60, 1, "R9");
    run_line(0, 16, 15, 16, 30, 50, 0, "R8");
    run_line(1, 16, 15, 8, 50, 30, 0, "R8");

    // R1: abort a line holding a partial pixel, then run a clean line
    @(negedge clk);
    start = 1; mode24 = 1; start_bit = 5'd24; end_bit = 5'd0; word_cnt = 8'd5;
    @(negedge clk);
    start = 0; in_valid = 1; in_data = 32'hffff_ffff;
    @(negedge clk);
    in_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    check(!busy && !px_valid && !in_ready, "R1", "idle after mid-line reset",
          {29'd0, busy, px_valid, in_ready}, 0);
    run_line(1, 0, 2, 8, 70, 70, 0, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule